// File: doc/BRIEF.md
# Chip-Select Unit with Wait-State DTACK and Window Conflict Detection

This block decodes every bus cycle against a set of programmable address windows. When a cycle's strobe is first seen, each enabled window compares the masked address with its masked base. The unit drives the chip select of every window that hits. After the number of wait states programmed for the selected window, it returns a data-transfer acknowledge (DTACK). If more than one window hits the same address, the overlap is recorded in a sticky status flag. When enabled, the overlap also produces a bus error in place of DTACK.

Three mode bits shape the timing. The first adds one wait state to cycles driven by an external master. The second turns window overlaps into bus errors. The third selects how locked read-modify-write cycles are timed. In split mode, both the read and the write portion get the programmed wait states. In continuous mode, only the read portion gets them. The caller marks the write portion of a locked cycle with a phase input. The window bases, masks, enables and wait counts are static configuration inputs. The mode bits sit in a small register that clears on reset.

Top module: `cs_dtack_unit`

## Requirements
- R1: Window i hits when its enable bit is 1 and (addr & mask_i) == (base_i & mask_i). Bit i of `cs` (window 0 in bit 0) rises after the first clock edge that samples `strobe` high, and every hitting window is driven.
- R2: For an internal master with one hitting window of programmed count W (0..7), `dtack` is first high after edge E0+W+1, where E0 is the edge that first samples `strobe`.
- R3: With mode bit 0 (external-master extra wait) set, a cycle with `ext_master`=1 gets W+1 wait states. An internal master still gets W.
- R4: With mode bit 0 clear, an external master gets exactly W wait states.
- R5: With mode bit 1 (conflict bus error) set, a cycle where two or more windows hit raises `berr` together with the chip selects, and `dtack` stays low for the whole cycle.
- R6: With mode bit 1 clear, an overlap raises no `berr`. DTACK then follows the wait count of the lowest-index hitting window.
- R7: `conflict_flag` is set by any overlap, whatever mode bit 1 holds. It stays set until a cycle with `conflict_clr`=1, and a new overlap in that same cycle wins.
- R8: With mode bit 2 (split locked) set, a write portion (`locked_wr`=1) gets the programmed wait states.
- R9: With mode bit 2 clear, a write portion (`locked_wr`=1) gets zero programmed wait states.
- R10: `cs`, `dtack` and `berr` are all low after the clock edge that samples `strobe` low.
- R11: After reset, the mode bits (`mode_q`) and `conflict_flag` are zero, and `cs`, `dtack` and `berr` are low. A cycle with `mode_wr`=1 loads `mode_wdata` into the mode bits.
- R12: An address that hits no window drives no chip select and no DTACK.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| addr | input | ADDR_W | Bus address |
| strobe | input | 1 | Address strobe, active high |
| ext_master | input | 1 | 1 when an external master owns the cycle |
| locked_wr | input | 1 | 1 on the write portion of a locked cycle |
| win_en | input | NUM_WIN | Per-window enable |
| win_base | input | NUM_WIN*ADDR_W | Packed window bases, window 0 in the low bits |
| win_mask | input | NUM_WIN*ADDR_W | Packed compare masks, 1 = bit compared |
| win_wait | input | NUM_WIN*WAIT_W | Packed per-window wait counts |
| mode_wr | input | 1 | Load the mode bits |
| mode_wdata | input | 3 | Mode bits: [0] external extra wait, [1] conflict bus error, [2] split locked |
| conflict_clr | input | 1 | Write-one clear of the conflict flag |
| cs | output | NUM_WIN | Chip selects, active high |
| dtack | output | 1 | Transfer acknowledge, active high |
| berr | output | 1 | Bus error, active high |
| conflict_flag | output | 1 | Sticky overlap status |
| mode_q | output | 3 | Current mode bits |

## Verification
Each window is driven alone with a different wait count (0, 2 and 7). This shows that the wait count follows the selected window and is not a shared value, and that the chip select goes to the right bit. One window is run under all four combinations of master source and extra-wait bit, which separates R3 from R4. An address in the region where two windows overlap is run with the bus-error bit off and then on. This distinguishes a late DTACK from a suppressed one, and shows the flag setting in both cases. The write portion of a locked cycle is run in both locked modes, and an unmapped address checks that nothing answers.

// File: rtl/cs_pkg.sv
// Package: shared types for the chip-select unit.
// Assumes: consumers import it before declaring ports or state.
package cs_pkg;
    typedef enum logic {
        ST_IDLE   = 1'b0,
        ST_ACTIVE = 1'b1
    } cyc_state_t;

    // Mode bits; field order matches mode_wdata[2:0].
    typedef struct packed {
        logic split_locked;   // [2]
        logic conflict_berr;  // [1]
        logic ext_extra_wait; // [0]
    } mode_t;
endpackage

// File: rtl/cs_window_match.sv
// Module: cs_window_match
// Compares the address against every window. Returns the hit vector,
// an overlap indicator and the wait count of the lowest-index hit.
// Assumes: packed configuration vectors, window 0 in the low bits.
module cs_window_match #(
    parameter int NUM_WIN = 4,
    parameter int ADDR_W  = 24,
    parameter int WAIT_W  = 3
) (
    input  logic [ADDR_W-1:0]         addr,
    input  logic [NUM_WIN-1:0]        win_en,
    input  logic [NUM_WIN*ADDR_W-1:0] win_base,
    input  logic [NUM_WIN*ADDR_W-1:0] win_mask,
    input  logic [NUM_WIN*WAIT_W-1:0] win_wait,
    output logic [NUM_WIN-1:0]        hit,
    output logic                      overlap,
    output logic [WAIT_W-1:0]         sel_wait
);
    // One masked comparator per window.
    for (genvar g = 0; g < NUM_WIN; g++) begin : g_cmp
        logic [ADDR_W-1:0] m;
        assign m = win_mask[g*ADDR_W +: ADDR_W];
        assign hit[g] = win_en[g] &&
            ((addr & m) == (win_base[g*ADDR_W +: ADDR_W] & m));
    end

    // Overlap means more than one window hits.
    assign overlap = ($countones(hit) > 1);

    // Lowest-index hit supplies the wait count.
    always_comb begin
        sel_wait = '0;
        for (int i = NUM_WIN - 1; i >= 0; i--) begin
            if (hit[i]) sel_wait = win_wait[i*WAIT_W +: WAIT_W];
        end
    end
endmodule

// File: rtl/cs_wait_timer.sv
// Module: cs_wait_timer
// Down-counter for wait states. It loads on cycle start and reports
// expiry once it reaches zero.
// Assumes: load is a single-cycle pulse at the start of each bus cycle.
module cs_wait_timer #(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             expired
);
    logic [CNT_W-1:0] cnt_q;

    // Load on start, otherwise count down to zero and hold.
    always_ff @(posedge clk) begin
        if (!rst_n)            cnt_q <= '0;
        else if (load)         cnt_q <= load_val;
        else if (cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
    end

    assign expired = (cnt_q == '0);

    // R2: the count falls by exactly one per idle-load cycle.
    assert_timer_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1));
endmodule

// File: rtl/cs_cfg_regs.sv
// Module: cs_cfg_regs
// Holds the mode bits and the sticky conflict flag.
// Assumes: overlap_set is a single-cycle pulse at cycle start.
module cs_cfg_regs
    import cs_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       mode_wr,
    input  logic [2:0] mode_wdata,
    input  logic       overlap_set,
    input  logic       conflict_clr,
    output mode_t      mode,
    output logic       conflict_flag
);
    // Mode register, cleared on reset.
    always_ff @(posedge clk) begin
        if (!rst_n)       mode <= '0;
        else if (mode_wr) mode <= mode_t'(mode_wdata);
    end

    // Sticky flag; a new overlap wins over a clear.
    always_ff @(posedge clk) begin
        if (!rst_n)            conflict_flag <= 1'b0;
        else if (overlap_set)  conflict_flag <= 1'b1;
        else if (conflict_clr) conflict_flag <= 1'b0;
    end

    // R7: the flag only drops through a clear request.
    assert_flag_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (conflict_flag && !conflict_clr) |=> conflict_flag);

    // R7: an overlap always leaves the flag set.
    assert_flag_set_R7: assert property (@(posedge clk) disable iff (!rst_n)
        overlap_set |=> conflict_flag);
endmodule

// File: rtl/cs_dtack_unit.sv
// Module: cs_dtack_unit (top)
// Runs the bus-cycle sequence. It drives chip selects on the first
// sampled strobe, then raises DTACK after the computed wait states
// or BERR on an enabled overlap. All outputs release after strobe
// is sampled low.
// Assumes: strobe stays high until DTACK or BERR has been seen.
module cs_dtack_unit
    import cs_pkg::*;
#(
    parameter int NUM_WIN = 4,
    parameter int ADDR_W  = 24,
    parameter int WAIT_W  = 3
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [ADDR_W-1:0]         addr,
    input  logic                      strobe,
    input  logic                      ext_master,
    input  logic                      locked_wr,
    input  logic [NUM_WIN-1:0]        win_en,
    input  logic [NUM_WIN*ADDR_W-1:0] win_base,
    input  logic [NUM_WIN*ADDR_W-1:0] win_mask,
    input  logic [NUM_WIN*WAIT_W-1:0] win_wait,
    input  logic                      mode_wr,
    input  logic [2:0]                mode_wdata,
    input  logic                      conflict_clr,
    output logic [NUM_WIN-1:0]        cs,
    output logic                      dtack,
    output logic                      berr,
    output logic                      conflict_flag,
    output logic [2:0]                mode_q
);
    localparam int CNT_W = WAIT_W + 1;

    cyc_state_t         state_q;
    logic [NUM_WIN-1:0] hit, cs_q;
    logic               overlap, start, expired, berr_q, dtack_q;
    logic [WAIT_W-1:0]  sel_wait;
    logic [CNT_W-1:0]   wait_total;
    mode_t              mode;

    cs_window_match #(.NUM_WIN(NUM_WIN), .ADDR_W(ADDR_W), .WAIT_W(WAIT_W)) u_match (
        .addr(addr), .win_en(win_en), .win_base(win_base), .win_mask(win_mask),
        .win_wait(win_wait), .hit(hit), .overlap(overlap), .sel_wait(sel_wait)
    );

    cs_cfg_regs u_cfg (
        .clk(clk), .rst_n(rst_n), .mode_wr(mode_wr), .mode_wdata(mode_wdata),
        .overlap_set(start && overlap), .conflict_clr(conflict_clr),
        .mode(mode), .conflict_flag(conflict_flag)
    );

    assign start = (state_q == ST_IDLE) && strobe;

    // Wait total: programmed count (skipped on continuous locked writes) plus external extra.
    always_comb begin
        wait_total = (locked_wr && !mode.split_locked) ? '0 : CNT_W'(sel_wait);
        if (ext_master && mode.ext_extra_wait) wait_total = wait_total + 1'b1;
    end

    cs_wait_timer #(.CNT_W(CNT_W)) u_timer (
        .clk(clk), .rst_n(rst_n), .load(start), .load_val(wait_total), .expired(expired)
    );

    // Bus-cycle sequencer: select, wait, acknowledge, release.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cs_q    <= '0;
            berr_q  <= 1'b0;
            dtack_q <= 1'b0;
        end else begin
            case (state_q)
                ST_IDLE: if (strobe) begin
                    state_q <= ST_ACTIVE;
                    cs_q    <= hit;
                    berr_q  <= overlap && mode.conflict_berr;
                end
                default: if (!strobe) begin
                    state_q <= ST_IDLE;
                    cs_q    <= '0;
                    berr_q  <= 1'b0;
                    dtack_q <= 1'b0;
                end else if (expired && !berr_q && cs_q != '0) begin
                    dtack_q <= 1'b1;
                end
            endcase
        end
    end

    assign cs     = cs_q;
    assign dtack  = dtack_q;
    assign berr   = berr_q;
    assign mode_q = mode;

    // R5: a bus error never comes with an acknowledge.
    assert_no_dtack_with_berr_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !(dtack_q && berr_q));

    // R10: a sampled-low strobe releases every output.
    assert_release_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!strobe && state_q == ST_ACTIVE) |=> (cs_q == '0 && !dtack_q && !berr_q));

    // R12: no acknowledge without a selected window.
    assert_dtack_needs_cs_R12: assert property (@(posedge clk) disable iff (!rst_n)
        dtack_q |-> (cs_q != '0));

    // R2: acknowledge only rises while the strobe is held.
    assert_dtack_in_cycle_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dtack_q) |-> $past(strobe));
endmodule

// File: tb/tb_cs_dtack_unit.sv
module tb_cs_dtack_unit;
    localparam int NW = 4, AW = 24, WW = 3;

    logic clk = 1'b0, rst_n = 1'b0;
    logic [AW-1:0] addr = '0;
    logic strobe = 0, ext_master = 0, locked_wr = 0;
    logic [NW-1:0] win_en = 4'b1111;
    logic [NW*AW-1:0] win_base, win_mask;
    logic [NW*WW-1:0] win_wait;
    logic mode_wr = 0, conflict_clr = 0;
    logic [2:0] mode_wdata = '0;
    logic [NW-1:0] cs;
    logic dtack, berr, conflict_flag;
    logic [2:0] mode_q;
    int n_chk = 0, n_bad = 0;

    always #10 clk = ~clk;

    // Windows: 0 @0x00xxxx W2, 1 @0x01xxxx W0, 2 @0x02xxxx W7, 3 @0x028000-0x02FFFF W4 (overlaps 2)
    assign win_base = {24'h028000, 24'h020000, 24'h010000, 24'h000000};
    assign win_mask = {24'hFF8000, 24'hFF0000, 24'hFF0000, 24'hFF0000};
    assign win_wait = {3'd4, 3'd7, 3'd0, 3'd2};

    cs_dtack_unit #(.NUM_WIN(NW), .ADDR_W(AW), .WAIT_W(WW)) dut (
        .clk(clk), .rst_n(rst_n), .addr(addr), .strobe(strobe), .ext_master(ext_master),
        .locked_wr(locked_wr), .win_en(win_en), .win_base(win_base), .win_mask(win_mask),
        .win_wait(win_wait), .mode_wr(mode_wr), .mode_wdata(mode_wdata),
        .conflict_clr(conflict_clr), .cs(cs), .dtack(dtack), .berr(berr),
        .conflict_flag(conflict_flag), .mode_q(mode_q)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic set_mode(input logic [2:0] m);
        @(negedge clk); mode_wr = 1; mode_wdata = m;
        @(negedge clk); mode_wr = 0;
    endtask

    task automatic pulse_clear();
        @(negedge clk); conflict_clr = 1;
        @(negedge clk); conflict_clr = 0;
    endtask

    // Runs one cycle; returns measured waits (-1 if no DTACK), chip selects and BERR seen after E0.
    task automatic bus_cycle(input logic [AW-1:0] a, input logic ext, input logic lw,
                             output int waits, output logic [NW-1:0] cs_seen, output logic berr_seen);
        @(negedge clk);
        addr = a; ext_master = ext; locked_wr = lw; strobe = 1;
        waits = -1; cs_seen = '0; berr_seen = 0;
        for (int k = 1; k <= 14; k++) begin
            @(posedge clk); @(negedge clk);
            if (k == 1) begin cs_seen = cs; berr_seen = berr; end
            if (dtack) begin waits = k - 2; break; end
        end
        strobe = 0;
        @(posedge clk); @(negedge clk);
        chk(cs == '0 && !dtack && !berr, "R10 release", {cs, dtack, berr}, 0);
        ext_master = 0; locked_wr = 0;
    endtask

    task automatic t_reset();
        chk(cs == '0 && !dtack && !berr, "R11 outputs at reset", {cs, dtack, berr}, 0);
        chk(mode_q == 3'b000, "R11 mode at reset", mode_q, 0);
        chk(!conflict_flag, "R11 flag at reset", conflict_flag, 0);
    endtask

    task automatic t_windows();
        int w; logic [NW-1:0] c; logic b;
        bus_cycle(24'h000040, 0, 0, w, c, b);
        chk(c == 4'b0001, "R1 window0 select", c, 1);
        chk(w == 2, "R2 window0 waits", w, 2);
        bus_cycle(24'h01ABCD, 0, 0, w, c, b);
        chk(c == 4'b0010, "R1 window1 select", c, 2);
        chk(w == 0, "R2 window1 waits", w, 0);
        bus_cycle(24'h020100, 0, 0, w, c, b);
        chk(c == 4'b0100, "R1 window2 select", c, 4);
        chk(w == 7, "R2 window2 waits", w, 7);
    endtask

    task automatic t_ext_master();
        int w; logic [NW-1:0] c; logic b;
        bus_cycle(24'h000010, 1, 0, w, c, b);
        chk(w == 2, "R4 ext master, bit clear", w, 2);
        set_mode(3'b001);
        chk(mode_q == 3'b001, "R11 mode load", mode_q, 1);
        bus_cycle(24'h000010, 1, 0, w, c, b);
        chk(w == 3, "R3 ext master extra wait", w, 3);
        bus_cycle(24'h000010, 0, 0, w, c, b);
        chk(w == 2, "R3 internal master unaffected", w, 2);
        set_mode(3'b000);
    endtask

    task automatic t_no_match();
        int w; logic [NW-1:0] c; logic b;
        bus_cycle(24'h300000, 0, 0, w, c, b);
        chk(c == '0, "R12 no chip select", c, 0);
        chk(w == -1, "R12 no dtack", w, -1);
    endtask

    task automatic t_conflict();
        int w; logic [NW-1:0] c; logic b;
        bus_cycle(24'h028100, 0, 0, w, c, b);
        chk(c == 4'b1100, "R1 both overlapping selects", c, 12);
        chk(!b, "R6 no berr when disabled", b, 0);
        chk(w == 7, "R6 lowest-index waits", w, 7);
        chk(conflict_flag, "R7 flag set, berr disabled", conflict_flag, 1);
        pulse_clear();
        chk(!conflict_flag, "R7 flag cleared", conflict_flag, 0);
        set_mode(3'b010);
        bus_cycle(24'h028100, 0, 0, w, c, b);
        chk(b, "R5 berr on overlap", b, 1);
        chk(w == -1, "R5 dtack suppressed", w, -1);
        chk(conflict_flag, "R7 flag set, berr enabled", conflict_flag, 1);
        bus_cycle(24'h000000, 0, 0, w, c, b);
        chk(conflict_flag, "R7 flag sticky", conflict_flag, 1);
        pulse_clear();
        set_mode(3'b000);
    endtask

    task automatic t_locked();
        int w; logic [NW-1:0] c; logic b;
        bus_cycle(24'h000020, 0, 1, w, c, b);
        chk(w == 0, "R9 continuous write portion", w, 0);
        bus_cycle(24'h000020, 0, 0, w, c, b);
        chk(w == 2, "R9 continuous read portion", w, 2);
        set_mode(3'b100);
        bus_cycle(24'h000020, 0, 1, w, c, b);
        chk(w == 2, "R8 split write portion", w, 2);
        set_mode(3'b000);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1;
        t_windows();
        t_ext_master();
        t_no_match();
        t_conflict();
        t_locked();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=1 expected=0");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule